// File: doc/BRIEF.md
# Staging SRAM Window with Copy Commands

This block gives a host a narrow register window onto two banks of 32-bit word memory used to stage configuration images. The host loads a shared word pointer, together with two advance flags, into the pointer register and then streams words through one of two data registers: one reaches bank A and the other bank B, both at the pointer. Each data access moves the pointer on by one word only when the flag for that bank is set. This allows a long image to be streamed through bank A alone. It also allows both banks to be stepped in lockstep by setting the flag of the bank that is accessed second.

A command register starts one of three long-running operations on one of two target devices: saving the staged image to a nonvolatile store, loading it back from the store, or rebooting the device from the store. The block does not move the data itself. It hands the request to an external agent over a level request and acknowledge pair, and a ready flag stays low until the agent acknowledges. A reset register gives software a full soft reset, after which ready stays low for a fixed settling time and must be polled.

The bank depth is `2**ADDR_W` words. Setting `ADDR_W` = 19 gives 0x80000 words, and the default is smaller. The pointer is always read back in a 20-bit field.

Top module: `staging_sram_port`

## Requirements
- R1: A write to the pointer register (offset 0) loads the pointer from data bits [ADDR_W-1:0], the bank-A advance flag from bit 31 and the bank-B advance flag from bit 30. Reading offset 0 returns bit 31 = A flag, bit 30 = B flag, bits [29:20] = 0 and bits [19:0] = pointer zero-extended.
- R2: A write to offset 1 stores the word in bank A at the pointer, and a write to offset 2 stores it in bank B. A read of offset 1 or 2 returns that bank's word at the pointer on `reg_rdata` from the cycle after the read strobe, and `reg_rdata` holds until the next read. The two banks are independent.
- R3: After a read or write of offset 1, the pointer increases by one only if the A flag is set. After an access to offset 2, it increases only if the B flag is set. Otherwise the pointer is unchanged.
- R4: Advancing from the top word `2**ADDR_W-1` wraps the pointer to 0.
- R5: A command write (offset 3) with code bits [1:0] = 1 (save to store), 2 (load from store) or 3 (reboot) while `ready` is high raises `cmd_req` from the next cycle. `cmd_op` equals bits [1:0] and `cmd_dev` equals bit 8. `cmd_req` and `ready` = 0 are held until a cycle with `cmd_ack` high, and `ready` is high again from the following cycle. An acknowledge with no request has no effect.
- R6: A valid command written while `ready` is low, including in the cycle in which `cmd_ack` arrives, is ignored and sets a sticky error flag. A command with code 0 is always ignored and sets nothing. Reading offset 3 returns bit 1 = error and bit 0 = ready.
- R7: Writing exactly 0x0000FFFF to offset 4 clears the pointer, both flags and the error flag, and withdraws any pending request. It also holds `ready` low for `RST_CYCLES` cycles after the write. Any other value written to offset 4 has no effect.
- R8: After hardware reset the pointer, the flags and the error flag are 0, `cmd_req` is low, `ready` is high and `reg_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register offset: 0 pointer, 1 bank A, 2 bank B, 3 command/status, 4 soft reset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| ready | output | 1 | High when no command or soft reset is in progress |
| cmd_req | output | 1 | Request to the copy/reboot agent |
| cmd_op | output | 2 | Requested operation code |
| cmd_dev | output | 1 | Target device select |
| cmd_ack | input | 1 | Completion pulse from the agent |

## Verification
The collision of interest is a command completing while a new command is written: when `cmd_ack` arrives in the same cycle as a command write, the write still sees the block as busy. The bench holds a command pending, then drives the acknowledge and a second valid command write on the same clock. It then judges that `cmd_req` drops, that no new request appears, and that the status read shows error set with ready high. A second collision, a data access that advances the pointer from the top word, is provoked by loading the pointer with the last address and checking the readback for zero.

// File: rtl/staging_sram_port.sv
module staging_sram_port #(
  parameter int ADDR_W     = 10,
  parameter int RST_CYCLES = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        ready,
  output logic        cmd_req,
  output logic [1:0]  cmd_op,
  output logic        cmd_dev,
  input  logic        cmd_ack
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int RCW   = $clog2(RST_CYCLES + 1);
  localparam logic [2:0] OFF_PTR = 3'd0;
  localparam logic [2:0] OFF_A   = 3'd1;
  localparam logic [2:0] OFF_B   = 3'd2;
  localparam logic [2:0] OFF_CMD = 3'd3;
  localparam logic [2:0] OFF_RST = 3'd4;
  localparam logic [ADDR_W-1:0] PMAX = '1;

  logic [31:0]       mem_a [DEPTH];
  logic [31:0]       mem_b [DEPTH];
  logic [ADDR_W-1:0] ptr;
  logic              inc_a, inc_b, err;
  logic [RCW-1:0]    rcnt;

  wire acc_a  = (reg_wr | reg_rd) && reg_addr == OFF_A;
  wire acc_b  = (reg_wr | reg_rd) && reg_addr == OFF_B;
  wire ptr_wr = reg_wr && reg_addr == OFF_PTR;
  wire cmd_wr = reg_wr && reg_addr == OFF_CMD && reg_wdata[1:0] != 2'd0;
  wire srst   = reg_wr && reg_addr == OFF_RST && reg_wdata == 32'h0000_FFFF;
  wire busy   = cmd_req || rcnt != '0;
  wire step   = (acc_a && inc_a) || (acc_b && inc_b);

  assign ready = !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0; inc_a <= 1'b0; inc_b <= 1'b0; err <= 1'b0;
      cmd_req <= 1'b0; cmd_op <= 2'd0; cmd_dev <= 1'b0; rcnt <= '0;
    end else if (srst) begin
      ptr <= '0; inc_a <= 1'b0; inc_b <= 1'b0; err <= 1'b0;
      cmd_req <= 1'b0; rcnt <= RCW'(RST_CYCLES);
    end else begin
      if (rcnt != '0) rcnt <= rcnt - 1'b1;
      if (ptr_wr) begin
        ptr   <= reg_wdata[ADDR_W-1:0];
        inc_a <= reg_wdata[31];
        inc_b <= reg_wdata[30];
      end else if (step) begin
        ptr <= ptr + 1'b1;
      end
      if (cmd_req && cmd_ack) cmd_req <= 1'b0;
      if (cmd_wr) begin
        if (busy) err <= 1'b1;
        else begin
          cmd_req <= 1'b1;
          cmd_op  <= reg_wdata[1:0];
          cmd_dev <= reg_wdata[8];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (reg_wr && reg_addr == OFF_A) mem_a[ptr] <= reg_wdata;
    if (reg_wr && reg_addr == OFF_B) mem_b[ptr] <= reg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reg_rdata <= '0;
    else if (reg_rd) begin
      case (reg_addr)
        OFF_PTR: reg_rdata <= {inc_a, inc_b, 10'd0, 20'(ptr)};
        OFF_A:   reg_rdata <= mem_a[ptr];
        OFF_B:   reg_rdata <= mem_b[ptr];
        OFF_CMD: reg_rdata <= {30'd0, err, ready};
        default: reg_rdata <= '0;
      endcase
    end
  end

  a_r3_ptr_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!ptr_wr && !srst && !acc_a && !acc_b) |=> $stable(ptr));

  a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!ptr_wr && !srst && acc_a && inc_a && ptr == PMAX) |=> ptr == '0);

  a_r5_req_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_req && !cmd_ack && !srst) |=> (cmd_req && $stable(cmd_op) && $stable(cmd_dev)));

  a_r6_busy_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !ready && !srst) |=> ($stable(cmd_op) && $stable(cmd_dev) && err));

  a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !srst) |=> err);

  a_r7_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (ptr == '0 && !err && !cmd_req && !ready && !inc_a && !inc_b));
endmodule

// File: tb/staging_sram_port_tb.sv
`timescale 1ns/1ps
module staging_sram_port_tb;
  localparam int ADDR_W = 10;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int RSTC   = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 0, reg_rd = 0, cmd_ack = 0;
  logic [2:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic ready, cmd_req, cmd_dev;
  logic [1:0] cmd_op;

  int vectors = 0, fails = 0, cyc = 0;
  string phase = "R8";

  always #2.5 clk = ~clk;

  staging_sram_port #(.ADDR_W(ADDR_W), .RST_CYCLES(RSTC)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ready(ready), .cmd_req(cmd_req), .cmd_op(cmd_op), .cmd_dev(cmd_dev),
    .cmd_ack(cmd_ack));

  // behavioural reference
  logic [31:0] ma [int];
  logic [31:0] mb [int];
  int  m_ptr = 0, m_rcnt = 0;
  bit  m_ia = 0, m_ib = 0, m_err = 0, m_req = 0, m_dev = 0, m_known = 1;
  int  m_op = 0;
  logic [31:0] m_rd = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ptr = 0; m_rcnt = 0; m_ia = 0; m_ib = 0; m_err = 0; m_req = 0;
      m_dev = 0; m_op = 0; m_rd = 0; m_known = 1;
    end else begin
      bit busy_m;
      busy_m = m_req || m_rcnt != 0;
      if (reg_wr && reg_addr == 4 && reg_wdata == 32'h0000FFFF) begin
        m_ptr = 0; m_ia = 0; m_ib = 0; m_err = 0; m_req = 0; m_rcnt = RSTC;
      end else begin
        if (m_rcnt > 0) m_rcnt--;
        if (reg_rd) begin
          m_known = 1;
          case (reg_addr)
            0: m_rd = (32'(m_ia) << 31) | (32'(m_ib) << 30) | 32'(m_ptr);
            1: if (ma.exists(m_ptr)) m_rd = ma[m_ptr]; else m_known = 0;
            2: if (mb.exists(m_ptr)) m_rd = mb[m_ptr]; else m_known = 0;
            3: m_rd = {30'd0, m_err, !busy_m};
            default: m_rd = 0;
          endcase
        end
        if (reg_wr && reg_addr == 1) ma[m_ptr] = reg_wdata;
        if (reg_wr && reg_addr == 2) mb[m_ptr] = reg_wdata;
        if (reg_wr && reg_addr == 0) begin
          m_ptr = int'(reg_wdata[ADDR_W-1:0]); m_ia = reg_wdata[31]; m_ib = reg_wdata[30];
        end else if (((reg_wr || reg_rd) && reg_addr == 1 && m_ia) ||
                     ((reg_wr || reg_rd) && reg_addr == 2 && m_ib))
          m_ptr = (m_ptr + 1) % DEPTH;
        if (m_req && cmd_ack) m_req = 0;
        if (reg_wr && reg_addr == 3 && reg_wdata[1:0] != 0) begin
          if (busy_m) m_err = 1;
          else begin m_req = 1; m_op = reg_wdata[1:0]; m_dev = reg_wdata[8]; end
        end
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    #1;
    chk({phase, " ready"}, 32'(ready), 32'(!(m_req || m_rcnt != 0)));
    chk({phase, " cmd_req"}, 32'(cmd_req), 32'(m_req));
    if (m_req) begin
      chk({phase, " cmd_op"}, 32'(cmd_op), 32'(m_op));
      chk({phase, " cmd_dev"}, 32'(cmd_dev), 32'(m_dev));
    end
    if (m_known) chk({phase, " rdata"}, reg_rdata, m_rd);
  end

  always @(posedge clk) if (cyc > 100000) begin
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d, input bit ack = 0);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d; cmd_ack = ack;
    @(negedge clk); reg_wr = 0; cmd_ack = 0;
  endtask

  task automatic rd(input logic [2:0] a);
    @(negedge clk); reg_rd = 1; reg_addr = a;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ack;
    @(negedge clk); cmd_ack = 1;
    @(negedge clk); cmd_ack = 0;
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1;
    idle(2);
    phase = "R8";
    chk("R8 ready after reset", 32'(ready), 1);
    chk("R8 no request after reset", 32'(cmd_req), 0);
    chk("R8 rdata after reset", reg_rdata, 0);
    rd(0); chk("R8 pointer after reset", reg_rdata, 0);

    phase = "R1";
    wr(0, 32'h8000_0005); rd(0); chk("R1 readback A flag", reg_rdata, 32'h8000_0005);
    wr(0, 32'h4000_0123); rd(0); chk("R1 readback B flag", reg_rdata, 32'h4000_0123);

    phase = "R2";
    wr(0, 32'h8000_0005);
    for (int i = 0; i < 3; i++) wr(1, 32'hA000_0000 + i);
    wr(0, 32'h4000_0005);
    for (int i = 0; i < 3; i++) wr(2, 32'hB000_0000 + i);
    wr(0, 32'h8000_0005);
    for (int i = 0; i < 3; i++) begin
      rd(1); chk("R2 bank A word", reg_rdata, 32'hA000_0000 + i);
    end
    wr(0, 32'h4000_0006);
    rd(2); chk("R2 bank B word", reg_rdata, 32'hB000_0001);
    idle(2); chk("R2 rdata held", reg_rdata, 32'hB000_0001);

    phase = "R3";
    wr(0, 32'h4000_0010); wr(1, 32'h1111_1111); wr(1, 32'h2222_2222);
    rd(0); chk("R3 no advance on A when only B flag", reg_rdata, 32'h4000_0010);
    rd(1); chk("R3 last A write wins", reg_rdata, 32'h2222_2222);
    wr(2, 32'h3333_3333); rd(0); chk("R3 advance on B", reg_rdata, 32'h4000_0011);
    wr(0, 32'hC000_0020); wr(1, 1); wr(2, 2); rd(0);
    chk("R3 both flags advance twice", reg_rdata, 32'hC000_0022);
    wr(0, 32'h0000_0030); rd(1); rd(2); rd(0);
    chk("R3 no flags no advance", reg_rdata, 32'h0000_0030);

    phase = "R4";
    wr(0, 32'h8000_03FF); wr(1, 32'hDEAD_BEEF); rd(0);
    chk("R4 wrap to zero", reg_rdata, 32'h8000_0000);
    wr(0, 32'h4000_03FF); rd(2); rd(0);
    chk("R4 wrap on B read", reg_rdata, 32'h4000_0000);

    phase = "R5";
    wr(3, 32'h0000_0101);
    chk("R5 request raised", 32'(cmd_req), 1);
    chk("R5 op save", 32'(cmd_op), 1);
    chk("R5 device 1", 32'(cmd_dev), 1);
    chk("R5 ready low", 32'(ready), 0);
    idle(4); ack;
    chk("R5 ready back", 32'(ready), 1);
    ack; chk("R5 stray ack no effect", 32'(cmd_req), 0);
    wr(3, 32'h0000_0003); chk("R5 reboot dev0 op", 32'(cmd_op), 3);
    chk("R5 reboot dev0 dev", 32'(cmd_dev), 0);
    ack;

    phase = "R6";
    rd(3); chk("R6 status clean", reg_rdata, 32'h1);
    wr(3, 32'h0000_0100); chk("R6 code 0 ignored", 32'(cmd_req), 0);
    wr(3, 32'h0000_0002); idle(1);
    wr(3, 32'h0000_0103); chk("R6 busy cmd keeps op", 32'(cmd_op), 2);
    chk("R6 busy cmd keeps dev", 32'(cmd_dev), 0);
    rd(3); chk("R6 error set while busy", reg_rdata, 32'h2);
    ack; rd(3); chk("R6 error sticky", reg_rdata, 32'h3);
    wr(7, 0); wr(4, 32'h0000_FFFF); idle(RSTC + 1);
    wr(3, 32'h0000_0001); idle(2);
    wr(3, 32'h0000_0102, 1'b1);
    chk("R6 collided cmd ignored", 32'(cmd_req), 0);
    rd(3); chk("R6 collision flags error", reg_rdata, 32'h3);

    phase = "R7";
    wr(0, 32'hC000_0077); wr(4, 32'h0000_1234); rd(0);
    chk("R7 other value no effect", reg_rdata, 32'hC000_0077);
    wr(3, 32'h0000_0001);
    wr(4, 32'h0000_FFFF);
    chk("R7 request withdrawn", 32'(cmd_req), 0);
    idle(RSTC - 2); chk("R7 ready still low", 32'(ready), 0);
    idle(2); chk("R7 ready restored", 32'(ready), 1);
    rd(0); chk("R7 pointer cleared", reg_rdata, 0);
    rd(3); chk("R7 error cleared", reg_rdata, 32'h1);
    idle(3);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule